// File: doc/BRIEF.md
# Dual-Mode Baud Clock Generator

This block produces the bit-rate clock shared by a serial transmitter and receiver. It drives that clock as a level on `bclk_out`. It also raises a one-cycle enable, `bclk_en`, that marks each rising edge of the clock in the system clock domain. A single down-counter times every half-period, and its reload value sets the rate. The reload value comes from one of two rate sources.

In prescale mode, the half-period is a base of 5 or 15 system clocks multiplied by `2^pow_sel`. This gives full periods of 10 or 30 times a power of two. In time-constant mode, the half-period is `tc + 2` system clocks, which gives a period of `2·(tc+2)` with a 50% duty cycle. The all-ones select code (`pow_sel = 7`) overrides both modes: the generator stops, and a synchronized copy of the external clock `ext_clk` drives the output instead.

The controller has three states. In `ST_LOW` the output is low and the counter runs. In `ST_HIGH` the output is high and the counter runs. In `ST_EXT` the output follows the external clock. The state transitions are:

- **T_RISE**: `ST_LOW`→`ST_HIGH` when the counter reaches zero.
- **T_FALL**: `ST_HIGH`→`ST_LOW` when the counter reaches zero.
- **T_TO_EXT**: any state→`ST_EXT` whenever the select is 7.
- **T_FROM_EXT**: `ST_EXT`→`ST_LOW` when the select leaves 7. The counter is left at zero, so T_RISE follows on the next clock.

Each zero-count transition reloads the counter from the current configuration.

Top module: `baud_gen`

## Requirements
- R1: While `rst_n` is low, `bclk_out` and `bclk_en` are 0 and the state is `ST_LOW` with a zero count.
- R2: With `tc_mode`=0 and `pow_sel` s in 0..6, `bclk_out` is high for H and low for H system clocks. H is 5·2^s when `pre_sel`=0 and 15·2^s when `pre_sel`=1, so the period is 10·2^s or 30·2^s.
- R3: With `tc_mode`=1 and `pow_sel`≠7, `bclk_out` is high for `tc`+2 and low for `tc`+2 system clocks, for any 16-bit `tc` including 0.
- R4: With `pow_sel`=7, regardless of `tc_mode`, `bclk_out` follows `ext_clk`. The delay is three system clock edges: two synchronizer flops plus the output register.
- R5: `bclk_en` is high for exactly the one cycle in which `bclk_out` has just gone from 0 to 1, and at no other time.
- R6: A configuration change during a half-period does not shorten or lengthen that half. The new length applies from the next zero-count reload.
- R7: When `pow_sel` leaves 7, `bclk_out` is 0 after the next edge and rises on the edge after that, starting a full new period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pre_sel | input | 1 | Prescale choice: 0 selects the /10 base, 1 selects the /30 base |
| pow_sel | input | 3 | Power-of-two exponent 0..6; 7 selects the external clock |
| tc_mode | input | 1 | 0 = prescale mode, 1 = time-constant mode |
| tc | input | 16 | Time constant for time-constant mode |
| ext_clk | input | 1 | External bit clock, asynchronous |
| bclk_en | output | 1 | One-cycle pulse at each rising edge of the generated clock |
| bclk_out | output | 1 | Generated clock level |

## Verification
The bench builds the block with its default parameters: a 16-bit time constant, a 3-bit exponent, and bases 5 and 15. With these defaults every prescale combination is reachable, up to the longest half-period of 960 clocks. So is the shortest time-constant half-period of 2, and time constants in the thousands. The random vectors mix both modes, and directed cases cover the following:
- the extremes of both modes;
- the external-clock override in both modes;
- a mid-period change of the time constant;
- the restart after the external clock is released.

// File: rtl/baud_pkg.sv
package baud_pkg;
    typedef enum logic [1:0] {
        ST_LOW  = 2'd0,
        ST_HIGH = 2'd1,
        ST_EXT  = 2'd2
    } bg_state_e;
endpackage

// File: rtl/baud_reload.sv
// Computes the counter reload value (half-period minus one) from the configuration.
module baud_reload #(
    parameter int TC_W    = 16,
    parameter int POW_W   = 3,
    parameter int LO_BASE = 5,
    parameter int HI_BASE = 15
) (
    input  logic             pre_sel,
    input  logic [POW_W-1:0] pow_sel,
    input  logic             tc_mode,
    input  logic [TC_W-1:0]  tc,
    output logic [TC_W:0]    reload
);
    localparam int CNT_W  = TC_W + 1;
    localparam int NSLOT  = 2 ** POW_W;

    logic [CNT_W-1:0] lo_tab [NSLOT];
    logic [CNT_W-1:0] hi_tab [NSLOT];

    // One table slot per exponent; the all-ones code is the external select.
    generate
        for (genvar g = 0; g < NSLOT; g++) begin : g_slot
            if (g == NSLOT - 1) begin : g_ext
                assign lo_tab[g] = '0;
                assign hi_tab[g] = '0;
            end else begin : g_pow
                assign lo_tab[g] = CNT_W'(LO_BASE * (2 ** g) - 1);
                assign hi_tab[g] = CNT_W'(HI_BASE * (2 ** g) - 1);
            end
        end
    endgenerate

    always_comb begin
        if (tc_mode) begin
            reload = CNT_W'(tc) + CNT_W'(1);
        end else if (pre_sel) begin
            reload = hi_tab[pow_sel];
        end else begin
            reload = lo_tab[pow_sel];
        end
    end
endmodule

// File: rtl/baud_downcnt.sv
// Half-period down-counter with synchronous load.
module baud_downcnt #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         zero
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/baud_sync.sv
// Multi-flop synchronizer for the external clock.
module baud_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign level = chain[STAGES-1];
endmodule

// File: rtl/baud_gen.sv
module baud_gen
    import baud_pkg::*;
#(
    parameter int TC_W    = 16,
    parameter int POW_W   = 3,
    parameter int LO_BASE = 5,
    parameter int HI_BASE = 15,
    parameter int SYNC_N  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pre_sel,
    input  logic [POW_W-1:0] pow_sel,
    input  logic             tc_mode,
    input  logic [TC_W-1:0]  tc,
    input  logic             ext_clk,
    output logic             bclk_en,
    output logic             bclk_out
);
    localparam int               CNT_W    = TC_W + 1;
    localparam logic [POW_W-1:0] EXT_CODE = '1;
    localparam logic [CNT_W-1:0] MAX_LOAD = CNT_W'(2 ** TC_W);

    bg_state_e        state, nxt;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] cnt;
    logic             cnt_zero;
    logic             cnt_load;
    logic             ext_lvl;
    logic             is_ext;
    logic             out_nxt;

    assign is_ext = (pow_sel == EXT_CODE);

    baud_reload #(
        .TC_W(TC_W), .POW_W(POW_W), .LO_BASE(LO_BASE), .HI_BASE(HI_BASE)
    ) u_reload (
        .pre_sel(pre_sel), .pow_sel(pow_sel), .tc_mode(tc_mode), .tc(tc),
        .reload(reload)
    );

    baud_downcnt #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(load_val),
        .cnt(cnt), .zero(cnt_zero)
    );

    baud_sync #(.STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ext_clk), .level(ext_lvl)
    );

    // Next-state and counter control
    always_comb begin
        nxt      = state;
        cnt_load = 1'b0;
        load_val = reload;
        if (is_ext) begin
            nxt      = ST_EXT;                 // T_TO_EXT
            cnt_load = 1'b1;
            load_val = '0;
        end else begin
            unique case (state)
                ST_LOW: if (cnt_zero) begin
                    nxt      = ST_HIGH;        // T_RISE
                    cnt_load = 1'b1;
                end
                ST_HIGH: if (cnt_zero) begin
                    nxt      = ST_LOW;         // T_FALL
                    cnt_load = 1'b1;
                end
                ST_EXT: begin
                    nxt      = ST_LOW;         // T_FROM_EXT
                    cnt_load = 1'b1;
                    load_val = '0;
                end
                default: nxt = ST_LOW;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_LOW;
        else        state <= nxt;
    end

    // Output register
    assign out_nxt = (nxt == ST_HIGH) || ((nxt == ST_EXT) && ext_lvl);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_out <= 1'b0;
            bclk_en  <= 1'b0;
        end else begin
            bclk_out <= out_nxt;
            bclk_en  <= out_nxt && !bclk_out;
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!bclk_out && !bclk_en && state == ST_LOW && cnt == '0)); // R1

    AST_HALF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_ext && state != ST_EXT && !cnt_zero) |=> $stable(bclk_out)); // R6

    AST_HALF_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_ext && state != ST_EXT && cnt_zero) |=> (bclk_out != $past(bclk_out))); // R2

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= MAX_LOAD); // R3

    AST_EN_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_en |-> (bclk_out && !$past(bclk_out))); // R5

    AST_EXT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ext && state == ST_EXT) |=> (bclk_out == $past(ext_lvl))); // R4

    AST_EXT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_ext && state == ST_EXT) |=> (!bclk_out && state == ST_LOW)); // R7
endmodule

// File: tb/tb_baud_gen.sv
`timescale 1ns/1ps
module tb_baud_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pre_sel = 1'b0;
    logic [2:0]  pow_sel = 3'd0;
    logic        tc_mode = 1'b0;
    logic [15:0] tc = 16'd0;
    logic        ext_clk = 1'b0;
    logic        bclk_en;
    logic        bclk_out;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    baud_gen dut (
        .clk(clk), .rst_n(rst_n), .pre_sel(pre_sel), .pow_sel(pow_sel),
        .tc_mode(tc_mode), .tc(tc), .ext_clk(ext_clk),
        .bclk_en(bclk_en), .bclk_out(bclk_out)
    );

    function automatic int exp_half(input logic p, input int s, input logic m, input int t);
        if (m) return t + 2;
        return (p ? 15 : 5) * (1 << s);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_en();
        while (!bclk_en) @(negedge clk);
    endtask

    // Starting at a rising edge: count high samples, then the full period.
    task automatic meas(output int hi, output int per);
        wait_en();
        hi = 0;
        while (bclk_out) begin
            hi++;
            @(negedge clk);
            if (hi == 1) check("R5 en width", int'(bclk_en), 0);
        end
        per = hi;
        while (!bclk_en) begin
            per++;
            @(negedge clk);
        end
    endtask

    task automatic run_cfg(input string req, input logic p, input int s,
                           input logic m, input int t);
        int hi, per, h;
        pre_sel = p; pow_sel = 3'(s); tc_mode = m; tc = 16'(t);
        h = exp_half(p, s, m, t);
        @(negedge clk);
        wait_en();
        @(negedge clk);
        meas(hi, per);
        check({req, " high"}, hi, h);
        check({req, " period"}, per, 2 * h);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int hi, per;
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        check("R1 out in reset", int'(bclk_out), 0);
        check("R1 en in reset", int'(bclk_en), 0);
        rst_n = 1'b1;

        // Directed corners, prescale mode (R2)
        run_cfg("R2 /10 s0", 1'b0, 0, 1'b0, 0);
        run_cfg("R2 /30 s6", 1'b1, 6, 1'b0, 0);
        run_cfg("R2 /10 s6", 1'b0, 6, 1'b0, 0);
        // Time-constant corners (R3)
        run_cfg("R3 tc0", 1'b0, 0, 1'b1, 0);
        run_cfg("R3 tc3000", 1'b1, 2, 1'b1, 3000);

        // Random mix
        for (int i = 0; i < 16; i++) begin
            logic m;
            m = 1'($urandom % 2);
            if (m) run_cfg("R3 rand", 1'($urandom % 2), int'($urandom % 7), 1'b1,
                           int'($urandom % 400));
            else   run_cfg("R2 rand", 1'($urandom % 2), int'($urandom % 5), 1'b0, 0);
        end

        // R6: change the time constant just after a rising edge
        run_cfg("R6 pre", 1'b0, 0, 1'b1, 100);
        wait_en();
        tc = 16'd10;
        hi = 0;
        while (bclk_out) begin hi++; @(negedge clk); end
        per = 0;
        while (!bclk_en) begin per++; @(negedge clk); end
        check("R6 old half kept", hi, 102);
        check("R6 new half next", per, 12);

        // R4: external clock in prescale mode, then in time-constant mode
        for (int k = 0; k < 2; k++) begin
            tc_mode = 1'(k); pow_sel = 3'd7; ext_clk = 1'b0;
            repeat (4) @(negedge clk);
            check("R4 ext low", int'(bclk_out), 0);
            ext_clk = 1'b1;
            repeat (2) @(negedge clk);
            check("R4 ext delay", int'(bclk_out), 0);
            @(negedge clk);
            check("R4 ext high", int'(bclk_out), 1);
            check("R5 en on ext rise", int'(bclk_en), 1);
            @(negedge clk);
            check("R5 en one cycle", int'(bclk_en), 0);
            ext_clk = 1'b0;
            repeat (3) @(negedge clk);
            check("R4 ext falls", int'(bclk_out), 0);
        end

        // R7: leave external with ext_clk high
        ext_clk = 1'b1;
        repeat (4) @(negedge clk);
        tc_mode = 1'b0; pre_sel = 1'b0; pow_sel = 3'd1;
        @(negedge clk);
        check("R7 low after exit", int'(bclk_out), 0);
        @(negedge clk);
        check("R7 rise", int'(bclk_out), 1);
        check("R7 en", int'(bclk_en), 1);
        meas(hi, per);
        check("R7 period", per, 20);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule